// File: doc/BRIEF.md
# Pipelined Binary-Field Polynomial Multiplier

This block multiplies two elements of GF(2^m) held in polynomial basis and returns c(x) = a(x)·b(x) mod g(x). Coefficient arithmetic is over GF(2): AND forms a product and XOR forms a sum. The degree m and the field polynomial g(x) are elaboration-time parameters. Any irreducible polynomial of modest degree can be used, for example 1011, 10011, 100101, 111011, 1011011, 1110011, 10111111, 11001011, 11010011, 101011111, 110001101 or 110101001. Bit m of the pattern is the x^m coefficient.

The datapath is a network of small nodes, and each node depends on at most four input bits, so it fits a single 4-input look-up table. The first level forms symmetric partial-product nodes. A diagonal node is ai·bi. A cross node is ai·bj XOR aj·bi, because both terms always land in the same output bits. Each output bit then reduces the nodes that reach it through its own private tree of 4-input XOR nodes. These trees duplicate logic instead of sharing partial sums across outputs. A register stage follows every node level. The pipeline accepts one operand pair per clock with no stall, and a valid bit travels alongside the data.

Top module: `gf2m_pipe_mul`

## Requirements
- R1: With the default parameters (m = 8, g = 110001101, bit 8 being x^8), every valid result c equals the carry-less product of a and b reduced modulo g.
- R2: The same product rule holds for m = 3 with g = 1011 and for m = 5 with g = 100101.
- R3: out_valid rises exactly LAT clock cycles after in_valid is sampled high. LAT = 1 + max(1, ceil(log4(m(m+1)/2))), which gives 4 for m = 8 and 3 for m = 3 and m = 5.
- R4: An operand pair can be presented on every clock cycle. A burst of N consecutive valid inputs produces N consecutive valid results, in order.
- R5: While rst_n is low, and on the first edge after it is released, out_valid is 0 and c is 0.
- R6: A cycle with in_valid low produces out_valid low LAT cycles later.
- R7: When either operand is zero, the result is zero.
- R8: When b = 1 (only bit 0 set), the result equals a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears all pipeline registers |
| in_valid | input | 1 | Marks a and b as a pair to multiply this cycle |
| a | input | M | First operand, bit i is the x^i coefficient |
| b | input | M | Second operand, bit i is the x^i coefficient |
| out_valid | output | 1 | Marks c as the result of the pair sampled LAT cycles earlier |
| c | output | M | Reduced product, bit i is the x^i coefficient |

## Verification
Each result is due exactly LAT rising edges after its operands are sampled: 4 edges for the m = 8 instance and 3 edges for the m = 3 and m = 5 instances. The bench drives inputs and samples outputs on falling edges. For each instance it keeps its own history of driven pairs, as deep as that instance's latency, and compares the outputs against the entry pushed LAT falling edges earlier. A lone valid pulse measures the latency directly. An exhaustive back-to-back sweep, followed by random traffic with bubbles, checks both the data and the valid alignment on every cycle.

// File: rtl/gf2m_pkg.sv
package gf2m_pkg;

  localparam int unsigned GF_MAXM = 16;
  typedef logic [GF_MAXM-1:0] gf_word_t;

  // number of symmetric partial-product nodes (i <= j)
  function automatic int unsigned pair_count(int unsigned m);
    return (m * (m + 1)) / 2;
  endfunction

  // slot of node (i, j), i <= j, in row-major upper-triangle order
  function automatic int unsigned pair_slot(int unsigned i, int unsigned j, int unsigned m);
    return i * m - (i * (i - 1)) / 2 + (j - i);
  endfunction

  // 4-input XOR levels needed to fold n leaves into one bit (at least one)
  function automatic int unsigned tree_levels(int unsigned n);
    int unsigned lv;
    int unsigned cap;
    lv  = 0;
    cap = 1;
    while (cap < n) begin
      cap = cap * 4;
      lv++;
    end
    return (lv == 0) ? 1 : lv;
  endfunction

  function automatic int unsigned pipe_latency(int unsigned m);
    return 1 + tree_levels(pair_count(m));
  endfunction

  function automatic gf_word_t low_mask(int unsigned m);
    return gf_word_t'((32'd1 << m) - 32'd1);
  endfunction

  // x^d mod g, poly_low holds g without its leading x^m term
  function automatic gf_word_t xpow_mod(int unsigned d, int unsigned m, gf_word_t poly_low);
    gf_word_t r;
    logic     carry;
    r = gf_word_t'(1);
    for (int unsigned s = 0; s < d; s++) begin
      carry = r[m-1];
      r = (r << 1) & low_mask(m);
      if (carry) r = r ^ poly_low;
    end
    return r;
  endfunction

  // bit-serial shift-and-reduce product, most significant multiplier bit first
  function automatic gf_word_t mul_ref(gf_word_t a, gf_word_t b, int unsigned m, gf_word_t poly_low);
    gf_word_t r;
    logic     carry;
    r = '0;
    for (int i = int'(m) - 1; i >= 0; i--) begin
      carry = r[m-1];
      r = (r << 1) & low_mask(m);
      if (carry) r = r ^ poly_low;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

endpackage

// File: rtl/gf2m_pair_stage.sv
module gf2m_pair_stage
  import gf2m_pkg::*;
#(
  parameter int unsigned M  = 8,
  parameter int unsigned NP = pair_count(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [M-1:0]  a,
  input  logic [M-1:0]  b,
  output logic [NP-1:0] pp_q
);

  logic [NP-1:0] pp_d;

  for (genvar i = 0; i < M; i++) begin : g_row
    for (genvar j = i; j < M; j++) begin : g_col
      localparam int unsigned SLOT = pair_slot(i, j, M);
      if (i == j) begin : g_diag
        // two-input node
        assign pp_d[SLOT] = a[i] & b[i];
      end else begin : g_cross
        // four-input node: both cross terms share every output equation
        assign pp_d[SLOT] = (a[i] & b[j]) ^ (a[j] & b[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pp_q <= '0;
    else        pp_q <= pp_d;
  end

endmodule

// File: rtl/gf2m_xor_tree.sv
module gf2m_xor_tree #(
  parameter int unsigned N      = 36,
  parameter int unsigned LEVELS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] leaves,
  output logic         sum_q
);

  localparam int unsigned W = 4 ** LEVELS;

  logic [W-1:0] padded;
  assign padded = W'(leaves);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int unsigned IN_W  = W >> (2 * l);
    localparam int unsigned OUT_W = IN_W / 4;
    logic [IN_W-1:0]  din;
    logic [OUT_W-1:0] q;

    if (l == 0) begin : g_first
      assign din = padded;
    end else begin : g_next
      assign din = g_lvl[l-1].q;
    end

    // each output bit is one 4-input node followed by a register
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else begin
        for (int o = 0; o < int'(OUT_W); o++) q[o] <= ^din[4*o +: 4];
      end
    end
  end

  assign sum_q = g_lvl[LEVELS-1].q[0];

endmodule

// File: rtl/gf2m_valid_pipe.sv
module gf2m_valid_pipe #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vin,
  output logic vout
);

  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[DEPTH-2:0], vin};
  end

  assign vout = sr[DEPTH-1];

endmodule

// File: rtl/gf2m_pipe_mul.sv
module gf2m_pipe_mul
  import gf2m_pkg::*;
#(
  parameter int unsigned M    = 8,
  parameter logic [M:0]  POLY = 9'b110001101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         out_valid,
  output logic [M-1:0] c
);

  localparam int unsigned NP       = pair_count(M);
  localparam int unsigned LEVELS   = tree_levels(NP);
  localparam int unsigned LAT      = 1 + LEVELS;
  localparam gf_word_t    POLY_LOW = gf_word_t'(POLY[M-1:0]);

  // which partial-product nodes reach output bit k
  function automatic logic [NP-1:0] leaf_mask(int unsigned k);
    logic [NP-1:0] mk;
    gf_word_t      r;
    mk = '0;
    for (int unsigned i = 0; i < M; i++) begin
      for (int unsigned j = i; j < M; j++) begin
        r = xpow_mod(i + j, M, POLY_LOW);
        mk[pair_slot(i, j, M)] = r[k];
      end
    end
    return mk;
  endfunction

  logic [NP-1:0] pp_q;

  gf2m_pair_stage #(.M(M), .NP(NP)) u_pairs (
    .clk  (clk),
    .rst_n(rst_n),
    .a    (a),
    .b    (b),
    .pp_q (pp_q)
  );

  // one private reduction tree per output bit (duplicated logic, no sharing)
  for (genvar k = 0; k < M; k++) begin : g_out
    localparam logic [NP-1:0] MASK = leaf_mask(k);
    logic [NP-1:0] leaves;
    assign leaves = pp_q & MASK;

    gf2m_xor_tree #(.N(NP), .LEVELS(LEVELS)) u_tree (
      .clk   (clk),
      .rst_n (rst_n),
      .leaves(leaves),
      .sum_q (c[k])
    );
  end

  gf2m_valid_pipe #(.DEPTH(LAT)) u_vpipe (
    .clk  (clk),
    .rst_n(rst_n),
    .vin  (in_valid),
    .vout (out_valid)
  );

endmodule

// File: rtl/gf2m_pipe_mul_chk.sv
module gf2m_pipe_mul_chk
  import gf2m_pkg::*;
#(
  parameter int unsigned M    = 8,
  parameter logic [M:0]  POLY = 9'b110001101
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [M-1:0] a,
  input logic [M-1:0] b,
  input logic         out_valid,
  input logic [M-1:0] c
);

  localparam int unsigned LAT      = pipe_latency(M);
  localparam gf_word_t    POLY_LOW = gf_word_t'(POLY[M-1:0]);

  logic [M-1:0]   a_h [LAT];
  logic [M-1:0]   b_h [LAT];
  logic [LAT-1:0] v_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_h <= '0;
      for (int i = 0; i < int'(LAT); i++) begin
        a_h[i] <= '0;
        b_h[i] <= '0;
      end
    end else begin
      v_h    <= {v_h[LAT-2:0], in_valid};
      a_h[0] <= a;
      b_h[0] <= b;
      for (int i = 1; i < int'(LAT); i++) begin
        a_h[i] <= a_h[i-1];
        b_h[i] <= b_h[i-1];
      end
    end
  end

  logic         due_valid;
  logic [M-1:0] due_a;
  logic [M-1:0] due_b;
  gf_word_t     exp_word;
  logic [M-1:0] exp_c;

  assign due_valid = v_h[LAT-1];
  assign due_a     = a_h[LAT-1];
  assign due_b     = b_h[LAT-1];
  assign exp_word  = mul_ref(gf_word_t'(due_a), gf_word_t'(due_b), M, POLY_LOW);
  assign exp_c     = exp_word[M-1:0];

  // R1 and R2: valid results match the serial reference
  a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (c == exp_c));

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == due_valid);

  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !due_valid |-> !out_valid);

  a_r5_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && (c == '0)));

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (due_valid && ((due_a == '0) || (due_b == '0))) |-> (c == '0));

  a_r8_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (due_valid && (due_b == M'(1))) |-> (c == due_a));

endmodule

bind gf2m_pipe_mul gf2m_pipe_mul_chk #(.M(M), .POLY(POLY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .a        (a),
  .b        (b),
  .out_valid(out_valid),
  .c        (c)
);

// File: tb/test_gf2m_pipe_mul.sv
`timescale 1ns/1ps
module test_gf2m_pipe_mul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] a_drv = '0;
  logic [15:0] b_drv = '0;

  always #4 clk = ~clk;

  logic       ov0, ov1, ov2;
  logic [7:0] c0;
  logic [2:0] c1;
  logic [4:0] c2;

  gf2m_pipe_mul #(.M(8), .POLY(9'b110001101)) i_gf2m_pipe_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(vld),
    .a(a_drv[7:0]), .b(b_drv[7:0]), .out_valid(ov0), .c(c0));

  gf2m_pipe_mul #(.M(3), .POLY(4'b1011)) i_gf2m_pipe_mul_m3 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld),
    .a(a_drv[2:0]), .b(b_drv[2:0]), .out_valid(ov1), .c(c1));

  gf2m_pipe_mul #(.M(5), .POLY(6'b100101)) i_gf2m_pipe_mul_m5 (
    .clk(clk), .rst_n(rst_n), .in_valid(vld),
    .a(a_drv[4:0]), .b(b_drv[4:0]), .out_valid(ov2), .c(c2));

  logic [2:0]  ov;
  logic [15:0] oc [3];
  assign ov    = {ov2, ov1, ov0};
  assign oc[0] = 16'(c0);
  assign oc[1] = 16'(c1);
  assign oc[2] = 16'(c2);

  int          m_of [3] = '{8, 3, 5};
  logic [16:0] g_of [3] = '{17'b110001101, 17'b1011, 17'b100101};
  int          lat  [3];

  logic        hv [3][8];
  logic [15:0] ha [3][8];
  logic [15:0] hb [3][8];

  int n_chk = 0;
  int n_fail = 0;

  // carry-less product, then fold high degrees down with g
  function automatic logic [15:0] tb_gfmul(logic [15:0] x, logic [15:0] y, int m, logic [16:0] g);
    logic [31:0] prod;
    prod = '0;
    for (int i = 0; i < m; i++) if (y[i]) prod = prod ^ (32'(x) << i);
    for (int d = 2 * m - 2; d >= m; d--) if (prod[d]) prod = prod ^ (32'(g) << (d - m));
    return prod[15:0];
  endfunction

  function automatic int tb_lat(int m);
    int n, lv, cap;
    n = (m * (m + 1)) / 2;
    lv = 0;
    cap = 1;
    while (cap < n) begin
      cap = cap * 4;
      lv++;
    end
    if (lv == 0) lv = 1;
    return lv + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int d,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s m=%0d actual=%h expected=%h", tag, m_of[d], act, exp);
    end
  endtask

  // falling edge: compare results due now, then drive the next pair
  task automatic cycle(input logic v, input logic [15:0] av, input logic [15:0] bv);
    @(negedge clk);
    for (int d = 0; d < 3; d++) begin
      int          lt;
      logic        ev;
      logic [15:0] msk, ex;
      string       tag;
      lt = lat[d];
      ev = hv[d][lt-1];
      check(ov[d] == ev, ev ? "R4" : "R6", d, 16'(ov[d]), 16'(ev));
      if (ev) begin
        ex = tb_gfmul(ha[d][lt-1], hb[d][lt-1], m_of[d], g_of[d]);
        if (ha[d][lt-1] == 0 || hb[d][lt-1] == 0) tag = "R7";
        else if (hb[d][lt-1] == 1) tag = "R8";
        else if (d == 0) tag = "R1";
        else tag = "R2";
        check(oc[d] == ex, tag, d, oc[d], ex);
      end
      for (int i = 7; i > 0; i--) begin
        hv[d][i] = hv[d][i-1];
        ha[d][i] = ha[d][i-1];
        hb[d][i] = hb[d][i-1];
      end
      msk = 16'((32'd1 << m_of[d]) - 1);
      hv[d][0] = v;
      ha[d][0] = av & msk;
      hb[d][0] = bv & msk;
    end
    vld   = v;
    a_drv = av;
    b_drv = bv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int first_t [3];
    void'($urandom(32'd20240611));
    for (int d = 0; d < 3; d++) begin
      lat[d] = tb_lat(m_of[d]);
      for (int i = 0; i < 8; i++) begin
        hv[d][i] = 1'b0;
        ha[d][i] = '0;
        hb[d][i] = '0;
      end
    end

    // R5: held in reset with active-looking traffic
    vld = 1'b1;
    a_drv = 16'h00B7;
    b_drv = 16'h005C;
    repeat (3) begin
      @(negedge clk);
      for (int d = 0; d < 3; d++) begin
        check(ov[d] == 1'b0, "R5", d, 16'(ov[d]), 16'h0);
        check(oc[d] == 16'h0, "R5", d, oc[d], 16'h0);
      end
    end
    vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 3; d++) check(oc[d] == 16'h0 && !ov[d], "R5", d, oc[d], 16'h0);

    // R3: lone pulse, measure the cycle count to out_valid
    cycle(1'b1, 16'h0005, 16'h0003);
    for (int d = 0; d < 3; d++) first_t[d] = 0;
    for (int t = 1; t <= 8; t++) begin
      cycle(1'b0, 16'h0, 16'h0);
      for (int d = 0; d < 3; d++) if (ov[d] && first_t[d] == 0) first_t[d] = t;
    end
    for (int d = 0; d < 3; d++)
      check(first_t[d] == lat[d], "R3", d, 16'(first_t[d]), 16'(lat[d]));

    // directed corners: R7 zero operand, R8 identity
    cycle(1'b1, 16'h00A5, 16'h0000);
    cycle(1'b1, 16'h0000, 16'h00FF);
    cycle(1'b1, 16'h0037, 16'h0001);
    cycle(1'b1, 16'h00FF, 16'h00FF);
    cycle(1'b1, 16'h0080, 16'h0080);
    repeat (6) cycle(1'b0, 16'h0, 16'h0);

    // R1, R2, R4: exhaustive back-to-back sweep
    for (int n = 0; n < 65536; n++) cycle(1'b1, 16'(n >> 8), 16'(n & 255));

    // R6 with random bubbles and random operands
    for (int n = 0; n < 3000; n++)
      cycle(($urandom % 4) != 0, 16'($urandom), 16'($urandom));

    repeat (8) cycle(1'b0, 16'h0, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule